// File: doc/BRIEF.md
# Push-Button Wiper Position Controller

This block steers the tap position of a 16-step digital potentiometer from two active-low push buttons, one for raising the wiper and one for lowering it. Each button is synchronized to the system clock. A press is accepted only once the line has stayed low for a debounce interval. A release is accepted only once the line has stayed high for a minimum gap. All durations are whole milliseconds, counted on a tick from a prescaler that divides the system clock by `CLK_PER_MS`.

A short press moves the wiper one tap. If the button stays down, the wiper keeps stepping at a slow interval. Once the button has been held for `FAST_AFTER_MS`, it steps at a fast interval instead. The position stops at both ends and never wraps. A single step is held back for one debounce window after the press is accepted, so that a second button arriving inside that window turns the gesture into a two-button gesture without first moving the wiper.

Holding both buttons together for `SHDN_MS` puts the block into shutdown. The shutdown flag opens the top of the resistor chain and the wiper is parked at tap 0. Shutdown is left by a later accepted press of either button, and the wiper returns to the tap it had on entry. If the second button arrives too late, every command is ignored until both buttons are up again.

Top module: `pbw_wiper_ctrl`

## Requirements
- R1: While reset is active, and after it is released, `tap_pos` is 0, `tap_sel` is 1 (bit 0 only) and `shdn` is 0.
- R2: A button that goes low for less than `DEB_MS` ms has no effect on any output.
- R3: An accepted press of the up button raises `tap_pos` by exactly one. An accepted press of the down button lowers it by exactly one. The step takes effect `DEB_MS` ms after acceptance, or at release if that comes first.
- R4: `tap_pos` saturates at 0 and at `TAPS-1` and never wraps.
- R5: While one button stays held, the position keeps stepping once every `SLOW_MS` ms after the first step.
- R6: Once a button has been held for `FAST_AFTER_MS` ms, the position steps once every `FAST_MS` ms.
- R7: Release ends auto-stepping, and the next press starts again with a single step and the slow interval. A high pulse shorter than `GAP_MS` ms does not count as a release.
- R8: Both buttons accepted within `DEB_MS` ms of each other and held for `SHDN_MS` ms set `shdn` to 1, with `tap_pos` reading 0 and `tap_sel` equal to 1. The wiper does not move while this gesture is held.
- R9: In shutdown, after both buttons have been released, an accepted press of either button clears `shdn` and restores the tap held on entry. That press makes no step.
- R10: If the second button is accepted after the first has already stepped, no further step and no shutdown occur until both buttons are released.
- R11: `tap_sel` always has exactly one bit set. That bit's index equals `tap_pos`, and it changes on the same clock edge as `tap_pos`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_n | input | 1 | Raise button, low while pressed |
| dn_n | input | 1 | Lower button, low while pressed |
| tap_pos | output | $clog2(TAPS) | Current wiper tap, 0 while in shutdown |
| tap_sel | output | TAPS | Registered one-hot tap select |
| shdn | output | 1 | High in shutdown; opens the top of the resistor chain |

## Verification
The controller state is a single stepping state machine with two counters. If a counter holds a wrong value, the interval between steps changes. That shows up as a wrong tap count at the end of a hold, within one slow or fast interval. If the machine is in a wrong state, a two-button gesture either moves the wiper or fails to reach shutdown. A late second button may also leave the wiper stepping. Each of these is visible on `tap_pos` and `shdn` within a few milliseconds of the gesture. If the select register disagrees with the position, `tap_sel` shows it on the same clock edge.

// File: rtl/pbw_pkg.sv
`timescale 1ns/1ps
package pbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,      // no button accepted
    ST_PEND,      // one button accepted, step held back for the pairing window
    ST_HOLD,      // one button held, auto-stepping
    ST_BOTH,      // valid two-button gesture, timing shutdown
    ST_LOCK,      // commands ignored until both buttons are up
    ST_OFF_HELD,  // shutdown, gesture buttons still down
    ST_OFF        // shutdown, armed for wake-up press
  } pbw_state_e;
endpackage

// File: rtl/pbw_tick.sv
`timescale 1ns/1ps
module pbw_tick #(
  parameter int CLK_PER_MS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(CLK_PER_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    tick_d = (cnt_q == LAST);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // Tick spacing: a tick is never followed by another inside one period (R5, R6 timing base)
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && CLK_PER_MS > 1) |=> !tick_q);
endmodule

// File: rtl/pbw_btn.sv
`timescale 1ns/1ps
module pbw_btn #(
  parameter int DEB_MS = 15,
  parameter int GAP_MS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_n,
  output logic pressed
);
  localparam int CMAX = (DEB_MS > GAP_MS) ? DEB_MS : GAP_MS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DEB_LAST = CW'(DEB_MS - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_MS - 1);

  logic          meta_q, sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pressed_q, pressed_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= btn_n;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    cnt_d     = cnt_q;
    pressed_d = pressed_q;
    if (!pressed_q) begin
      if (sync_q) begin
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q == DEB_LAST) begin
          pressed_d = 1'b1;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      if (!sync_q) begin
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q == GAP_LAST) begin
          pressed_d = 1'b0;
          cnt_d     = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pressed_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      pressed_q <= pressed_d;
    end
  end

  assign pressed = pressed_q;

  assert_accept_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pressed_q) |-> $past(!sync_q));
  assert_release_needs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pressed_q) |-> $past(sync_q));
endmodule

// File: rtl/pbw_decode.sv
`timescale 1ns/1ps
module pbw_decode #(
  parameter int TAPS = 16
) (
  input  logic [$clog2(TAPS)-1:0] idx,
  output logic [TAPS-1:0]         onehot
);
  localparam int PW = $clog2(TAPS);
  for (genvar g = 0; g < TAPS; g++) begin : g_bit
    assign onehot[g] = (idx == PW'(g));
  end
endmodule

// File: rtl/pbw_fsm.sv
`timescale 1ns/1ps
module pbw_fsm
  import pbw_pkg::*;
#(
  parameter int TAPS          = 16,
  parameter int DEB_MS        = 15,
  parameter int SLOW_MS       = 250,
  parameter int FAST_MS       = 50,
  parameter int FAST_AFTER_MS = 1000,
  parameter int SHDN_MS       = 2000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    up_on,
  input  logic                    dn_on,
  output logic [$clog2(TAPS)-1:0] pos_o,
  output logic [$clog2(TAPS)-1:0] pos_next_o,
  output logic                    off_o
);
  localparam int PW    = $clog2(TAPS);
  localparam int DMAX0 = (FAST_AFTER_MS > SHDN_MS) ? FAST_AFTER_MS : SHDN_MS;
  localparam int DMAX  = (DMAX0 > DEB_MS) ? DMAX0 : DEB_MS;
  localparam int DW    = $clog2(DMAX + 1);
  localparam int RMAX  = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS;
  localparam int RW    = $clog2(RMAX + 1);
  localparam logic [PW-1:0] TOP       = PW'(TAPS - 1);
  localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_MS - 1);
  localparam logic [DW-1:0] DEB_FULL  = DW'(DEB_MS);
  localparam logic [DW-1:0] SHDN_LAST = DW'(SHDN_MS - 1);
  localparam logic [DW-1:0] FAST_AT   = DW'(FAST_AFTER_MS);
  localparam logic [DW-1:0] DCAP      = DW'(DMAX);
  localparam logic [RW-1:0] SLOW_LAST = RW'(SLOW_MS - 1);
  localparam logic [RW-1:0] FAST_LAST = RW'(FAST_MS - 1);

  pbw_state_e    state_q, state_d;
  logic          dir_q, dir_d;          // 1: raising
  logic [DW-1:0] dcnt_q, dcnt_d;        // held / gesture duration in ms
  logic [RW-1:0] rcnt_q, rcnt_d;        // ms since last auto step
  logic [PW-1:0] pos_q, pos_d;
  logic          cur, oth, step, off_d;
  logic [RW-1:0] per_last;

  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    dcnt_d   = dcnt_q;
    rcnt_d   = rcnt_q;
    step     = 1'b0;
    cur      = dir_q ? up_on : dn_on;
    oth      = dir_q ? dn_on : up_on;
    per_last = (dcnt_q >= FAST_AT) ? FAST_LAST : SLOW_LAST;
    case (state_q)
      ST_IDLE: begin
        if (up_on && dn_on) begin
          state_d = ST_BOTH;
          dcnt_d  = '0;
        end else if (up_on || dn_on) begin
          state_d = ST_PEND;
          dir_d   = up_on;
          dcnt_d  = '0;
        end
      end
      ST_PEND: begin
        if (cur && oth) begin
          state_d = ST_BOTH;
          dcnt_d  = '0;
        end else if (!cur) begin
          step    = 1'b1;
          state_d = oth ? ST_LOCK : ST_IDLE;
        end else if (tick) begin
          if (dcnt_q == DEB_LAST) begin
            step    = 1'b1;
            state_d = ST_HOLD;
            dcnt_d  = DEB_FULL;
            rcnt_d  = '0;
          end else begin
            dcnt_d = dcnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (oth) begin
          state_d = ST_LOCK;
        end else if (!cur) begin
          state_d = ST_IDLE;
        end else if (tick) begin
          if (dcnt_q != DCAP) dcnt_d = dcnt_q + 1'b1;
          if (rcnt_q >= per_last) begin
            step   = 1'b1;
            rcnt_d = '0;
          end else begin
            rcnt_d = rcnt_q + 1'b1;
          end
        end
      end
      ST_BOTH: begin
        if (!up_on || !dn_on) begin
          state_d = ST_LOCK;
        end else if (tick) begin
          if (dcnt_q == SHDN_LAST) state_d = ST_OFF_HELD;
          else                     dcnt_d  = dcnt_q + 1'b1;
        end
      end
      ST_LOCK:     if (!up_on && !dn_on) state_d = ST_IDLE;
      ST_OFF_HELD: if (!up_on && !dn_on) state_d = ST_OFF;
      ST_OFF:      if (up_on || dn_on)   state_d = ST_LOCK;
      default:     state_d = ST_IDLE;
    endcase

    pos_d = pos_q;
    if (step) begin
      if (dir_q && pos_q != TOP)        pos_d = pos_q + 1'b1;
      else if (!dir_q && pos_q != '0)   pos_d = pos_q - 1'b1;
    end
    off_d      = (state_d == ST_OFF_HELD) || (state_d == ST_OFF);
    pos_next_o = off_d ? '0 : pos_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      dcnt_q  <= '0;
      rcnt_q  <= '0;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      dcnt_q  <= dcnt_d;
      rcnt_q  <= rcnt_d;
      pos_q   <= pos_d;
    end
  end

  assign off_o = (state_q == ST_OFF_HELD) || (state_q == ST_OFF);
  assign pos_o = off_o ? '0 : pos_q;

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q)) |-> (pos_q == $past(pos_q) + 1'b1 || pos_q == $past(pos_q) - 1'b1));
  assert_no_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == TOP) |=> (pos_q != '0 || TAPS <= 2));
  assert_no_wrap_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) |=> (pos_q != TOP || TAPS <= 2));
  assert_step_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q)) |-> ($past(tick) || $past(state_q) == ST_PEND));
  assert_gesture_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BOTH || off_o) |=> $stable(pos_q));
  assert_lock_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK) |=> $stable(pos_q));
endmodule

// File: rtl/pbw_wiper_ctrl.sv
`timescale 1ns/1ps
module pbw_wiper_ctrl #(
  parameter int CLK_PER_MS    = 10000,
  parameter int DEB_MS        = 15,
  parameter int GAP_MS        = 1,
  parameter int SLOW_MS       = 250,
  parameter int FAST_MS       = 50,
  parameter int FAST_AFTER_MS = 1000,
  parameter int SHDN_MS       = 2000,
  parameter int TAPS          = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    up_n,
  input  logic                    dn_n,
  output logic [$clog2(TAPS)-1:0] tap_pos,
  output logic [TAPS-1:0]         tap_sel,
  output logic                    shdn
);
  localparam int PW = $clog2(TAPS);
  localparam int NB = 2;  // index 0: raise, index 1: lower

  logic          rst_meta_q, rst_q;
  logic          tick;
  logic [NB-1:0] btn_n, btn_on;
  logic [PW-1:0] pos_next;
  logic [TAPS-1:0] sel_next, sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  pbw_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_q), .tick(tick));

  assign btn_n = {dn_n, up_n};

  for (genvar b = 0; b < NB; b++) begin : g_btn
    pbw_btn #(.DEB_MS(DEB_MS), .GAP_MS(GAP_MS)) u_btn (
      .clk(clk), .rst_n(rst_q), .tick(tick),
      .btn_n(btn_n[b]), .pressed(btn_on[b]));
  end

  pbw_fsm #(
    .TAPS(TAPS), .DEB_MS(DEB_MS), .SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS),
    .FAST_AFTER_MS(FAST_AFTER_MS), .SHDN_MS(SHDN_MS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_q), .tick(tick),
    .up_on(btn_on[0]), .dn_on(btn_on[1]),
    .pos_o(tap_pos), .pos_next_o(pos_next), .off_o(shdn));

  pbw_decode #(.TAPS(TAPS)) u_dec (.idx(pos_next), .onehot(sel_next));

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) sel_q <= TAPS'(1);
    else        sel_q <= sel_next;
  end

  assign tap_sel = sel_q;

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(tap_sel) == 1);
  assert_sel_match_R11: assert property (@(posedge clk) disable iff (!rst_q)
    tap_sel == (TAPS'(1) << tap_pos));
  assert_off_floor_R8: assert property (@(posedge clk) disable iff (!rst_q)
    shdn |-> tap_sel[0]);
endmodule

// File: tb/sim_pbw_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_pbw_wiper_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 10;   // clock cycles per ms tick
  localparam int TAPS       = 16;
  localparam int PW         = $clog2(TAPS);
  localparam int WD_CYCLES  = 150000;
  localparam int NV         = 15;
  // raise start, raise length, lower start, lower length (ms), expected tap, expected shutdown
  localparam int VEC [NV][6] = '{
    '{0, 12, 0, 0, 1, 0},     // R3 single raise
    '{0, 30, 0, 0, 3, 0},     // R5 slow repeat
    '{0, 60, 0, 0, 7, 0},     // R5 four slow steps
    '{0, 0, 0, 12, 6, 0},     // R3 single lower
    '{0, 0, 0, 76, 0, 0},     // R6 fast after long hold
    '{0, 76, 0, 0, 6, 0},     // R6 fast raise
    '{0, 1, 0, 0, 6, 0},      // R2 short raise glitch
    '{0, 0, 0, 1, 6, 0},      // R2 short lower glitch
    '{0, 120, 0, 0, 15, 0},   // R4 saturate top
    '{0, 12, 0, 0, 15, 0},    // R4 stay at top
    '{0, 20, 0, 20, 15, 0},   // R8 short two-button gesture
    '{30, 70, 0, 100, 13, 0}, // R10 late second button
    '{0, 100, 1, 99, 0, 1},   // R8 shutdown gesture
    '{0, 1, 0, 0, 0, 1},      // R2 glitch in shutdown
    '{0, 0, 0, 12, 13, 0}     // R9 wake restores tap
  };

  logic clk, rst_n, up_n, dn_n;
  logic [PW-1:0]   tap_pos;
  logic [TAPS-1:0] tap_sel;
  logic            shdn;
  int n_chk, n_bad;
  bit done;

  pbw_wiper_ctrl #(
    .CLK_PER_MS(CPM), .DEB_MS(3), .GAP_MS(2), .SLOW_MS(16), .FAST_MS(6),
    .FAST_AFTER_MS(64), .SHDN_MS(80), .TAPS(TAPS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n),
    .tap_pos(tap_pos), .tap_sel(tap_sel), .shdn(shdn));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string vtag(int i);
    case (i)
      0, 3:          return "R3";
      1, 2:          return "R5";
      4, 5:          return "R6";
      6, 7, 13:      return "R2";
      8, 9:          return "R4";
      10, 12:        return "R8";
      11:            return "R10";
      default:       return "R9";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(string req, int exp_pos, int exp_off);
    check(req, int'(tap_pos), exp_pos);
    check(req, int'(shdn), exp_off);
    check({req, " sel R11"}, int'(tap_sel), 1 << exp_pos);
  endtask

  task automatic wait_ms(int ms);
    repeat (ms * CPM) @(negedge clk);
  endtask

  task automatic run_vec(int us, int ul, int ds, int dl);
    int tend;
    tend = (us + ul > ds + dl) ? us + ul : ds + dl;
    for (int ms = 0; ms < tend; ms++) begin
      up_n = !(ms >= us && ms < us + ul);
      dn_n = !(ms >= ds && ms < ds + dl);
      wait_ms(1);
    end
    up_n = 1'b1;
    dn_n = 1'b1;
    wait_ms(10);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    up_n = 1'b1; dn_n = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check_out("R1 in reset", 0, 0);
    rst_n = 1'b1;
    wait_ms(2);
    check_out("R1 after reset", 0, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      check_out(vtag(i), VEC[i][4], VEC[i][5]);
    end

    // R7: a high pulse shorter than the release gap keeps one continuous press
    up_n = 1'b0; repeat (40) @(negedge clk);
    up_n = 1'b1; repeat (5)  @(negedge clk);
    up_n = 1'b0; repeat (40) @(negedge clk);
    up_n = 1'b1; wait_ms(10);
    check_out("R7 short gap", 14, 0);

    // R8: wiper stays put while the gesture is held, then shutdown
    up_n = 1'b0; dn_n = 1'b0;
    wait_ms(40);
    check_out("R8 mid gesture", 14, 0);
    wait_ms(60);
    up_n = 1'b1; dn_n = 1'b1;
    wait_ms(10);
    check_out("R8 shutdown", 0, 1);
    // R9: wake with raise restores, no step
    run_vec(0, 12, 0, 0);
    check_out("R9 wake", 14, 0);

    // R7: after release, a new hold starts slow again
    run_vec(0, 0, 0, 30);
    check_out("R7 restart slow", 12, 0);

    // R1: reset in the middle of a hold
    dn_n = 1'b0; wait_ms(30);
    rst_n = 1'b0; repeat (3) @(negedge clk);
    check_out("R1 reset mid hold", 0, 0);
    dn_n = 1'b1; wait_ms(2);
    rst_n = 1'b1; wait_ms(10);
    check_out("R1 after mid reset", 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule